// File: doc/BRIEF.md
# Row Write Buffer with Self-Timed Commit

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. It gathers the data bytes of one write transfer into a row-sized holding latch. Each held byte carries its own valid flag. On a commit pulse it runs a write cycle that lasts a fixed number of system clocks. During that cycle it copies every flagged byte into the memory array, and it raises `busy` so that the protocol engine stays off the bus.

A transfer opens with an address load. The upper address bits select the row and stay fixed. The lower `ROW_BITS` bits form an in-row pointer that steps after each accepted byte and wraps inside the row, so an overlong burst overwrites its own earliest entries. If the write-protect input is high at the load, the transfer is locked: no byte is accepted and a commit starts no cycle. An abort pulse discards the held bytes. When the cycle ends, the block pulses `done` and publishes the address that follows the last byte written. A registered read port gives the array contents to the read path.

The state machine has four states. `ST_IDLE` waits for a load. `ST_OPEN` accepts bytes. `ST_LOCKED` is a write-protected transfer that takes nothing. `ST_BUSY` is the timed cycle. The transitions are:
- `ST_IDLE` to `ST_OPEN` on a load with protect low.
- `ST_IDLE` to `ST_LOCKED` on a load with protect high.
- `ST_OPEN` to `ST_BUSY` on a commit while at least one byte is held or arriving, unless abort is also high.
- `ST_OPEN` to `ST_IDLE` on an abort, or on a commit with nothing held.
- `ST_LOCKED` to `ST_IDLE` on a commit or an abort.
- `ST_BUSY` to `ST_IDLE` when the cycle timer reaches its last count.

Top module: `page_wr_commit`

## Requirements
- R1: After reset `busy`, `done` and `byte_ack` are low, `next_addr` is 0, and every array byte reads FFh.
- R2: In `ST_OPEN`, a `byte_stb` without `abort` raises `byte_ack` in the same cycle. The byte is held for array address {row, pointer}, and only the low `ROW_BITS` bits of the pointer advance. A byte strobed in the same cycle as the commit is included in the write.
- R3: When more than 2^`ROW_BITS` bytes are sent, the pointer wraps to 0 within the same row. A later byte then replaces the earlier byte held for the same location.
- R4: A commit in `ST_OPEN` with at least one held or arriving byte raises `busy` from the next cycle for exactly `CYCLE_CLKS` cycles.
- R5: While `busy` is high, `addr_load`, `byte_stb`, `commit` and `abort` have no effect: `byte_ack` stays low and the array is unchanged by them.
- R6: The cycle writes only the latch entries whose valid flag is set. Every other array byte keeps its value, and all valid flags clear when the cycle ends.
- R7: In the first cycle after `busy` falls, `done` is high for exactly one cycle. `next_addr` then equals {row, pointer}, the address after the last byte accepted, and it changes at no other time.
- R8: If `wr_protect` is high at the load, `byte_ack` stays low for every byte, nothing is held, a commit starts no cycle and the array is unchanged.
- R9: An abort in `ST_OPEN` discards all held bytes and starts no cycle. When `abort` and `commit` arrive in the same cycle, abort wins.
- R10: A commit in `ST_OPEN` with no held or arriving byte starts no cycle and leaves `done` low.
- R11: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Opens a transfer at `load_addr` (taken in `ST_IDLE` only) |
| load_addr | input | ADDR_W | Start address: row in upper bits, pointer in low `ROW_BITS` |
| wr_protect | input | 1 | Write protect, sampled with `addr_load` |
| byte_stb | input | 1 | One data byte is offered |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | Start the timed write cycle |
| abort | input | 1 | Discard the transfer |
| rd_addr | input | ADDR_W | Array read address |
| byte_ack | output | 1 | Offered byte accepted this cycle |
| busy | output | 1 | Timed write cycle in progress |
| done | output | 1 | One-cycle pulse after the cycle ends |
| next_addr | output | ADDR_W | Address following the last byte written |
| rd_data | output | 8 | Registered array read data |

## Verification
The collision that matters is a commit that meets an abort, or a commit that meets a byte strobe, in the same cycle. The bench drives commit and abort together while a transfer holds bytes. It judges the outcome by `busy` staying low and a full array readback that shows no change. It also sends a final byte together with the commit and expects that byte in the array and in `next_addr`. A third overlap, control pulses arriving while `busy` is high, is provoked in the middle of every cycle. The bench checks that `byte_ack` stays low and that the readback shows nothing from them.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_LOCKED,
        ST_BUSY
    } pwc_state_e;
endpackage

// File: rtl/pwc_latch.sv
module pwc_latch #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign any_valid = |valid_q;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
    parameter int CYCLES = 80,
    localparam int CNT_W = $clog2(CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    assign last = (cnt == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int ADDR_W = 8,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= 8'hFF;
            end
            rdata <= 8'h00;
        end else begin
            if (we) begin
                mem_q[waddr] <= wdata;
            end
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/page_wr_commit.sv
module page_wr_commit
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ROW_BITS   = 6,
    parameter int CYCLE_CLKS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_protect,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              commit,
    input  logic              abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              byte_ack,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] next_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ROW_BITS;
    localparam int ROW_W = ADDR_W - ROW_BITS;
    localparam int CNT_W = $clog2(CYCLE_CLKS);

    pwc_state_e state_q, state_d;

    logic [ROW_W-1:0]    row_q;
    logic [ROW_BITS-1:0] ptr_q;
    logic                done_q;
    logic [ADDR_W-1:0]   next_addr_q;

    logic [CNT_W-1:0]    t_cnt;
    logic                t_last;
    logic                lat_wr, lat_clr, lat_valid, lat_any;
    logic [7:0]          lat_data;
    logic [ROW_BITS-1:0] flush_idx;
    logic                in_window;
    logic                mem_we;
    logic                load_take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = wr_protect ? ST_LOCKED : ST_OPEN;
            end
            ST_OPEN: begin
                if (abort)       state_d = ST_IDLE;
                else if (commit) state_d = (lat_any || byte_stb) ? ST_BUSY : ST_IDLE;
            end
            ST_LOCKED: begin
                if (abort || commit) state_d = ST_IDLE;
            end
            ST_BUSY: begin
                if (t_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        busy      = (state_q == ST_BUSY);
        load_take = (state_q == ST_IDLE) && addr_load;
        lat_wr    = (state_q == ST_OPEN) && byte_stb && !abort;
        byte_ack  = lat_wr;
        lat_clr   = ((state_q == ST_OPEN) && abort) || (busy && t_last);
        flush_idx = t_cnt[ROW_BITS-1:0];
        in_window = (32'(t_cnt) < DEPTH);
        mem_we    = busy && in_window && lat_valid;
    end

    // transfer address, completion report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q       <= '0;
            ptr_q       <= '0;
            done_q      <= 1'b0;
            next_addr_q <= '0;
        end else begin
            if (load_take) begin
                row_q <= load_addr[ADDR_W-1:ROW_BITS];
                ptr_q <= load_addr[ROW_BITS-1:0];
            end else if (lat_wr) begin
                ptr_q <= ptr_q + 1'b1;
            end
            done_q <= busy && t_last;
            if (busy && t_last) begin
                next_addr_q <= {row_q, ptr_q};
            end
        end
    end

    assign done      = done_q;
    assign next_addr = next_addr_q;

    pwc_latch #(.DEPTH(DEPTH)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lat_wr),
        .wr_idx    (ptr_q),
        .wr_data   (byte_in),
        .clr       (lat_clr),
        .rd_idx    (flush_idx),
        .rd_data   (lat_data),
        .rd_valid  (lat_valid),
        .any_valid (lat_any)
    );

    pwc_timer #(.CYCLES(CYCLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .cnt   (t_cnt),
        .last  (t_last)
    );

    pwc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr ({row_q, flush_idx}),
        .wdata (lat_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
    parameter int ADDR_W     = 8,
    parameter int CYCLE_CLKS = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              byte_ack,
    input logic              abort,
    input logic [ADDR_W-1:0] next_addr
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CYCLE_CLKS));

    a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !byte_ack);

    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_addr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_addr) |-> done);

    a_r9_abort_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !busy) |=> !busy);
endmodule

bind page_wr_commit pwc_chk #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .byte_ack  (byte_ack),
    .abort     (abort),
    .next_addr (next_addr)
);

// File: tb/page_wr_commit_tb.sv
`timescale 1ns/1ps
module page_wr_commit_tb;
    localparam int AW  = 8;
    localparam int RB  = 6;
    localparam int CYC = 80;
    localparam int DEP = 1 << RB;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_load = 0, wr_protect = 0, byte_stb = 0, commit = 0, abort = 0;
    logic [AW-1:0] load_addr = '0, rd_addr = '0;
    logic [7:0] byte_in = '0;
    logic byte_ack, busy, done;
    logic [AW-1:0] next_addr;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    page_wr_commit #(.ADDR_W(AW), .ROW_BITS(RB), .CYCLE_CLKS(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
        .wr_protect(wr_protect), .byte_stb(byte_stb), .byte_in(byte_in),
        .commit(commit), .abort(abort), .rd_addr(rd_addr), .byte_ack(byte_ack),
        .busy(busy), .done(done), .next_addr(next_addr), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] model_mem [WORDS];
    logic [7:0] lat_m [DEP];
    bit         lv_m [DEP];
    int         row_m, ptr_m;
    bit         open_m;

    function automatic int exp_next(int row, int ptr);
        return (row << RB) | (ptr & (DEP - 1));
    endfunction

    function automatic int step_ptr(int ptr);
        return (ptr + 1) & (DEP - 1);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEP; i++) lv_m[i] = 0;
        open_m = 0;
    endtask

    task automatic model_commit();
        for (int i = 0; i < DEP; i++)
            if (lv_m[i]) model_mem[(row_m << RB) | i] = lat_m[i];
        model_clear();
    endtask

    task automatic model_take(int d);
        lat_m[ptr_m] = 8'(d);
        lv_m[ptr_m]  = 1;
        ptr_m = step_ptr(ptr_m);
    endtask

    task automatic load(int a, bit wp);
        addr_load = 1; load_addr = AW'(a); wr_protect = wp;
        @(negedge clk);
        addr_load = 0; wr_protect = 0;
        open_m = !wp;
        row_m = a >> RB;
        ptr_m = a & (DEP - 1);
    endtask

    task automatic put(int d, string req);
        byte_stb = 1; byte_in = 8'(d);
        #1;
        chk(byte_ack == open_m, req, "byte_ack", int'(byte_ack), int'(open_m));
        @(negedge clk);
        byte_stb = 0;
        if (open_m) model_take(d);
    endtask

    task automatic finish_commit(bit with_byte, int d, bit expect_cycle, string req);
        int n;
        commit = 1;
        if (with_byte) begin byte_stb = 1; byte_in = 8'(d); end
        @(negedge clk);
        commit = 0; byte_stb = 0;
        if (with_byte && open_m) model_take(d);
        n = 0;
        while (busy && n < 1000) begin
            if (n == 3) begin
                // R5: control pulses during the cycle are ignored
                byte_stb = 1; byte_in = 8'h3C; addr_load = 1; load_addr = '0;
                commit = 1; abort = 1;
                #1;
                chk(byte_ack == 1'b0, "R5", "byte_ack while busy", int'(byte_ack), 0);
                @(negedge clk);
                byte_stb = 0; addr_load = 0; commit = 0; abort = 0;
            end else begin
                @(negedge clk);
            end
            n++;
        end
        if (expect_cycle) begin
            chk(n == CYC, "R4", "busy length", n, CYC);
            chk(done == 1'b1, "R7", "done after busy", int'(done), 1);
            chk(int'(next_addr) == exp_next(row_m, ptr_m), "R7", "next_addr",
                int'(next_addr), exp_next(row_m, ptr_m));
            @(negedge clk);
            chk(done == 1'b0, "R7", "done single pulse", int'(done), 0);
            model_commit();
        end else begin
            chk(n == 0, req, "no cycle", n, 0);
            chk(done == 1'b0, req, "done stays low", int'(done), 0);
            model_clear();
        end
    endtask

    task automatic abort_t(bit with_commit, string req);
        abort = 1; commit = with_commit;
        @(negedge clk);
        abort = 0; commit = 0;
        chk(busy == 1'b0, req, "busy after abort", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0, req, "busy later", int'(busy), 0);
        model_clear();
    endtask

    task automatic verify_array(string req);
        int bad = 0;
        int first_a = 0;
        int first_v = 0;
        for (int a = 0; a < WORDS; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            if (rd_data !== model_mem[a]) begin
                if (bad == 0) begin first_a = a; first_v = int'(rd_data); end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("array byte %0h (R11 readback)", first_a),
            first_v, int'(model_mem[first_a]));
    endtask

    initial begin
        #(5.0 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        for (int i = 0; i < WORDS; i++) model_mem[i] = 8'hFF;
        model_clear();
        row_m = 0; ptr_m = 0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(byte_ack == 1'b0, "R1", "byte_ack", int'(byte_ack), 0);
        chk(next_addr == '0, "R1", "next_addr", int'(next_addr), 0);
        verify_array("R1");

        // R2 single byte write
        load(8'h45, 0);
        put(8'hA5, "R2");
        finish_commit(0, 0, 1, "R4");
        verify_array("R2");

        // R3 wrap inside row: 70 bytes from offset 60 of row 2
        load(8'h80 + 60, 0);
        for (int i = 0; i < 70; i++) put(int'($urandom_range(0, 255)), "R3");
        finish_commit(0, 0, 1, "R3");
        verify_array("R3");

        // R8 write protect
        load(8'h10, 1);
        for (int i = 0; i < 3; i++) put(8'h11 * (i + 1), "R8");
        finish_commit(0, 0, 0, "R8");
        verify_array("R8");

        // R9 abort, then abort colliding with commit
        load(8'hC0, 0);
        for (int i = 0; i < 5; i++) put(8'h70 + i, "R2");
        abort_t(0, "R9");
        verify_array("R9");
        load(8'hC8, 0);
        put(8'h01, "R2");
        put(8'h02, "R2");
        abort_t(1, "R9");
        verify_array("R9");

        // R10 commit with nothing held
        load(8'h20, 0);
        finish_commit(0, 0, 0, "R10");

        // R2 byte in the same cycle as commit; R6 only flagged bytes written
        load(8'h30, 0);
        put(8'hD1, "R2");
        put(8'hD2, "R2");
        finish_commit(1, 8'h5C, 1, "R2");
        verify_array("R6");

        // random transfers
        for (int t = 0; t < 12; t++) begin
            int a, n;
            bit wp;
            a  = int'($urandom_range(0, WORDS - 1));
            n  = int'($urandom_range(1, 70));
            wp = ($urandom_range(0, 3) == 0);
            load(a, wp);
            for (int i = 0; i < n; i++) put(int'($urandom_range(0, 255)), wp ? "R8" : "R2");
            finish_commit(0, 0, !wp, wp ? "R8" : "R4");
            verify_array("R6");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule